// File: doc/BRIEF.md
# Flagged Combinational ALU

This block is a purely combinational arithmetic logic unit. Two operand words and a 4-bit operation code go in. A result word and three status flags come out: carry, zero and overflow. The block has no clock, no registers and no handshake. Every output follows its inputs within the same cycle, so a datapath that surrounds it decides when to capture the result.

The block offers three bitwise operations (AND, OR and NOR) and four arithmetic or compare operations: addition, subtraction, signed less-than and equality. These use one adder, which either adds or subtracts. Each flag has its own rule about which operations may raise it:

- Carry belongs to addition alone.
- Overflow belongs to addition and subtraction.
- Zero reflects the result of every operation.

An operation code outside the map gives an all-zero result.

The operand width is a parameter. The default width is 32 bits, and all rules scale to any width of two bits or more.

Top module: `flag_alu`

## Requirements
- R1: Code 4'b0000 gives the bitwise AND of the operands, code 4'b0001 gives the bitwise OR, and code 4'b1100 gives the bitwise NOR.
- R2: Code 4'b0010 gives A+B modulo 2^WIDTH. Carry is the carry out of the most significant bit.
- R3: Code 4'b0110 gives A-B modulo 2^WIDTH. Carry is 0.
- R4: During addition, overflow is 1 exactly when both operands have the same sign and the sign of the result differs from it.
- R5: During subtraction, overflow is 1 exactly when the operand signs differ and the sign of the result differs from the sign of A.
- R6: Code 4'b0111 places in bit 0 a 1 when A is less than B as signed two's-complement values, and 0 otherwise. The answer stays correct even when A-B overflows. All upper bits are 0.
- R7: Code 4'b1111 places in bit 0 a 1 when A equals B, and 0 otherwise. All upper bits are 0.
- R8: Zero is 1 exactly when every result bit is 0, for every code.
- R9: Overflow is 0 for every code other than add and subtract. Carry is 0 for every code other than add.
- R10: Any code not listed above gives a result of all zeros, with carry 0, overflow 0 and zero 1.
- R11: All outputs follow an input change without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand (A) |
| opnd_b | input | WIDTH | Second operand (B) |
| op_sel | input | 4 | Operation code |
| result | output | WIDTH | Operation result |
| carry_out | output | 1 | Carry out of the MSB, addition only |
| zero | output | 1 | Result is all zeros |
| overflow | output | 1 | Signed overflow, add and subtract only |

## Verification
The hardest case to reach is signed less-than when the internal subtraction overflows. In that case the sign of the difference alone gives the wrong answer. Random wide operands seldom land there, so the bench also builds a 4-bit instance. It sweeps every pair of operands against every one of the sixteen codes, which covers all overflowing comparisons and all unmapped codes. A 32-bit instance is then driven with extreme operands near the signed limits and with pseudo-random words.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'b0000,
    OP_OR  = 4'b0001,
    OP_ADD = 4'b0010,
    OP_SUB = 4'b0110,
    OP_SLT = 4'b0111,
    OP_NOR = 4'b1100,
    OP_EQ  = 4'b1111
  } alu_op_e;

  typedef struct packed {
    logic known;
    logic do_sub;
    logic keep_carry;
    logic keep_ovf;
  } alu_ctl_t;

  function automatic alu_ctl_t alu_decode(input logic [3:0] code);
    alu_ctl_t c;
    c = '0;
    unique case (code)
      OP_AND, OP_OR, OP_NOR, OP_EQ: c.known = 1'b1;
      OP_ADD: begin
        c.known      = 1'b1;
        c.keep_carry = 1'b1;
        c.keep_ovf   = 1'b1;
      end
      OP_SUB: begin
        c.known    = 1'b1;
        c.do_sub   = 1'b1;
        c.keep_ovf = 1'b1;
      end
      OP_SLT: begin
        c.known  = 1'b1;
        c.do_sub = 1'b1;
      end
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;

  always_comb begin
    b_eff       = sub ? ~b : b;
    {cout, sum} = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
    ovf         = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
  end

  always_comb begin
    if (sub) begin
      // R5
      sub_overflow_chk: assert (ovf == ((a[MSB] != b[MSB]) && (sum[MSB] != a[MSB])))
        else $error("subtract overflow mismatch");
    end else begin
      // R4
      add_overflow_chk: assert (ovf == ((a[MSB] == b[MSB]) && (sum[MSB] != a[MSB])))
        else $error("add overflow mismatch");
    end
  end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] and_v,
  output logic [WIDTH-1:0] or_v,
  output logic [WIDTH-1:0] nor_v
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign and_v[i] = a[i] & b[i];
    assign or_v[i]  = a[i] | b[i];
    assign nor_v[i] = ~(a[i] | b[i]);
  end

  always_comb begin
    // R1
    nor_invert_chk: assert ((nor_v ^ or_v) == {WIDTH{1'b1}})
      else $error("NOR is not the inverse of OR");
  end

endmodule

// File: rtl/alu_compare.sv
module alu_compare #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             diff_msb,
  input  logic             diff_ovf,
  output logic             less,
  output logic             equal
);
  always_comb begin
    less  = diff_msb ^ diff_ovf;
    equal = ~|(a ^ b);
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [3:0]       op_sel,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             zero,
  output logic             overflow
);
  localparam int HI_BITS = WIDTH - 1;

  alu_ctl_t         ctl;
  logic [WIDTH-1:0] as_sum;
  logic             as_cout;
  logic             as_ovf;
  logic [WIDTH-1:0] and_v, or_v, nor_v;
  logic             less, equal;

  assign ctl = alu_decode(op_sel);

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a(opnd_a), .b(opnd_b), .sub(ctl.do_sub),
    .sum(as_sum), .cout(as_cout), .ovf(as_ovf)
  );

  alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
    .a(opnd_a), .b(opnd_b),
    .and_v(and_v), .or_v(or_v), .nor_v(nor_v)
  );

  alu_compare #(.WIDTH(WIDTH)) u_compare (
    .a(opnd_a), .b(opnd_b),
    .diff_msb(as_sum[WIDTH-1]), .diff_ovf(as_ovf),
    .less(less), .equal(equal)
  );

  always_comb begin
    unique case (op_sel)
      OP_AND:  result = and_v;
      OP_OR:   result = or_v;
      OP_NOR:  result = nor_v;
      OP_ADD,
      OP_SUB:  result = as_sum;
      OP_SLT:  result = {{HI_BITS{1'b0}}, less};
      OP_EQ:   result = {{HI_BITS{1'b0}}, equal};
      default: result = '0;
    endcase
    carry_out = ctl.keep_carry & as_cout;
    overflow  = ctl.keep_ovf & as_ovf;
    zero      = ~|result;
  end

  always_comb begin
    // R8
    zero_flag_chk: assert (zero == (result == '0))
      else $error("zero flag disagrees with result");
    // R9
    no_overflow_chk: assert (!overflow || op_sel == OP_ADD || op_sel == OP_SUB)
      else $error("overflow raised outside add/subtract");
    // R9
    no_carry_chk: assert (!carry_out || op_sel == OP_ADD)
      else $error("carry raised outside add");
    // R6
    slt_signed_chk: assert (op_sel != OP_SLT ||
                            result == {{HI_BITS{1'b0}}, ($signed(opnd_a) < $signed(opnd_b))})
      else $error("signed less-than wrong");
    // R7
    eq_result_chk: assert (op_sel != OP_EQ ||
                           result == {{HI_BITS{1'b0}}, (opnd_a == opnd_b)})
      else $error("equality wrong");
    // R10
    unmapped_zero_chk: assert (ctl.known || (result == '0 && !carry_out && !overflow && zero))
      else $error("unmapped code produced nonzero outputs");
  end

endmodule

// File: tb/sim_flag_alu.sv
module sim_flag_alu;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [3:0]  a4, b4, op4, r4;
  logic        c4, z4, v4;
  logic [31:0] a32, b32, r32;
  logic [3:0]  op32;
  logic        c32, z32, v32;

  flag_alu #(.WIDTH(4)) u0 (
    .opnd_a(a4), .opnd_b(b4), .op_sel(op4),
    .result(r4), .carry_out(c4), .zero(z4), .overflow(v4)
  );

  flag_alu #(.WIDTH(32)) u1 (
    .opnd_a(a32), .opnd_b(b32), .op_sel(op32),
    .result(r32), .carry_out(c32), .zero(z32), .overflow(v32)
  );

  function automatic string tag_of(input int op);
    case (op)
      0, 1, 12: return "R1";
      2:        return "R2/R4";
      6:        return "R3/R5";
      7:        return "R6";
      15:       return "R7";
      default:  return "R10";
    endcase
  endfunction

  function automatic void model(input longint ua, input longint ub, input int op,
                                input int w, output longint r, output bit c,
                                output bit z, output bit v);
    longint mask, sa, sb, mx, mn, s;
    mask = (longint'(1) << w) - 1;
    mx = (longint'(1) << (w - 1)) - 1;
    mn = -(longint'(1) << (w - 1));
    sa = (ua > mx) ? ua - (longint'(1) << w) : ua;
    sb = (ub > mx) ? ub - (longint'(1) << w) : ub;
    r = 0; c = 0; v = 0;
    case (op)
      0:  r = ua & ub;
      1:  r = ua | ub;
      12: r = ~(ua | ub) & mask;
      2: begin
        s = ua + ub;
        r = s & mask;
        c = s > mask;
        v = (sa + sb > mx) || (sa + sb < mn);
      end
      6: begin
        r = (ua - ub) & mask;
        v = (sa - sb > mx) || (sa - sb < mn);
      end
      7:  r = (sa < sb) ? 1 : 0;
      15: r = (ua == ub) ? 1 : 0;
      default: r = 0;
    endcase
    z = (r == 0);
  endfunction

  task automatic compare(input string tag, input longint gr, input bit gc, input bit gz,
                         input bit gv, input longint er, input bit ec, input bit ez,
                         input bit ev);
    checks++;
    if (gr != er || gc != ec || gz != ez || gv != ev) begin
      failures++;
      $display("FAIL %s: actual r=%0h c=%0b z=%0b v=%0b expected r=%0h c=%0b z=%0b v=%0b",
               tag, gr, gc, gz, gv, er, ec, ez, ev);
    end
  endtask

  task automatic run32(input logic [31:0] a, input logic [31:0] b, input int op,
                       input string tag);
    longint er; bit ec, ez, ev;
    @(posedge clk);
    a32 = a; b32 = b; op32 = op[3:0];
    @(negedge clk);
    model(longint'(a), longint'(b), op, 32, er, ec, ez, ev);
    compare(tag, longint'(r32), c32, z32, v32, er, ec, ez, ev);
  endtask

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    return y ^ (y << 5);
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    longint er; bit ec, ez, ev;
    logic [31:0] rnd;
    a4 = 0; b4 = 0; op4 = 0;
    a32 = 0; b32 = 0; op32 = 0;
    @(negedge clk);
    // R8: zero operands under AND at start
    compare("R8 start", longint'(r32), c32, z32, v32, 0, 0, 1, 0);

    // Exhaustive 4-bit sweep: R1..R10
    for (int op = 0; op < 16; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          @(posedge clk);
          a4 = a[3:0]; b4 = b[3:0]; op4 = op[3:0];
          @(negedge clk);
          model(longint'(a), longint'(b), op, 4, er, ec, ez, ev);
          compare(tag_of(op), longint'(r4), c4, z4, v4, er, ec, ez, ev);
        end

    // Directed 32-bit corners
    run32(32'h7fffffff, 32'h00000001, 2, "R4 add pos overflow");
    run32(32'h80000000, 32'h80000000, 2, "R2 R4 add neg overflow carry");
    run32(32'hffffffff, 32'h00000001, 2, "R2 R8 carry with zero result");
    run32(32'h80000000, 32'h00000001, 6, "R5 sub overflow");
    run32(32'h00000000, 32'h00000001, 6, "R3 borrow gives no carry");
    run32(32'h80000000, 32'h00000001, 7, "R6 slt with overflow");
    run32(32'h7fffffff, 32'hffffffff, 7, "R6 slt pos vs neg");
    run32(32'h12345678, 32'h12345678, 15, "R7 equal");
    run32(32'h12345678, 32'h12345679, 15, "R7 not equal");
    run32(32'h0000ffff, 32'hffff0000, 12, "R1 nor to zero");
    run32(32'hdeadbeef, 32'h01234567, 9, "R10 unmapped");

    // Pseudo-random 32-bit, every code
    rnd = 32'h1badf00d;
    for (int i = 0; i < 400; i++)
      for (int op = 0; op < 16; op++) begin
        rnd = xs(rnd);
        a32 = rnd;
        rnd = xs(rnd);
        run32(a32, (i % 7 == 0) ? a32 : rnd, op, tag_of(op));
      end

    // R11: change inputs between edges, no clock edge before sampling
    @(posedge clk);
    #0.5;
    a32 = 32'h00000005; b32 = 32'h00000003; op32 = 4'b0110;
    #1;
    compare("R11 settle sub", longint'(r32), c32, z32, v32, 2, 0, 0, 0);
    a32 = 32'h00000003; b32 = 32'h00000005; op32 = 4'b0111;
    #0.5;
    compare("R11 settle slt", longint'(r32), c32, z32, v32, 1, 0, 0, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule